// File: doc/BRIEF.md
# Flash command sequence decoder

This block is a clocked model of the command front end and internal write engine of a byte-wide parallel NOR flash bank. A host drives active-low chip-select, write-strobe and output-enable lines, an address bus and a write data byte. A write cycle is the interval during which chip-select and write-strobe are both low. The block tracks these cycles against an unlock-protected command grammar and recognises three operations: byte program, 4 KB sector erase and whole-bank erase.

A recognised operation starts a timed internal job. During the job the block raises `busy`, discards every write cycle, and answers reads with a status byte instead of array data. When the count expires, the array is updated in one step. Program ANDs the written byte into the stored byte, so it can only clear bits. The erases set bytes back to FFh.

The stored array is a small alias of the full address space. It keeps the low `OFFS_KEEP` offset bits and the low `SECT_KEEP` bits of the sector field (address bits 17..12). All three job lengths are parameters scaled for simulation.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset `busy` is 0, every stored byte reads FFh, and `rdata` is 00h whenever no read cycle is active.
- R2: The program command is four write cycles: AAh at 5555h, 55h at 2AAAh, A0h at 5555h, then the target address and data byte. When the job ends, a read of the target returns the new stored byte.
- R3: A program stores the bitwise AND of the old byte and the written byte. It can clear bits but never set them.
- R4: A write cycle takes its address in the first clock cycle in which chip-select and write-strobe are both low. Its data is the value on the bus in the last such cycle. Address changes later in the cycle have no effect.
- R5: `busy` rises in the cycle after the clock edge that sees the final write cycle end. It stays high for exactly `PROG_CYC` cycles for a program.
- R6: The sector erase command is AAh at 5555h, 55h at 2AAAh, 80h at 5555h, AAh at 5555h, 55h at 2AAAh, then 30h at any address in the sector. Address bits 17..12 select the sector. Every byte of that sector becomes FFh, and other sectors keep their contents.
- R7: The bank erase command is the same five-cycle prefix followed by 10h at 5555h. Every byte becomes FFh.
- R8: Write cycles that finish while `busy` is high are discarded. A complete command issued during a job has no effect, and it leaves no partial progress behind.
- R9: A write cycle that does not match the expected step returns the decoder to idle without touching the array. This includes a final erase cycle of 10h at an address other than 5555h.
- R10: A read while `busy` is high returns a status byte. Bit 7 is the complement of bit 7 of the byte being programmed, and is 0 during an erase. Bit 6 is 0 on the first read after the job starts and inverts after each completed read. Bits 5..0 are 0.
- R11: The sector erase job lasts `SERA_CYC` cycles and the bank erase job lasts `BERA_CYC` cycles. Each length is set independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Array byte or status byte during an active read, else 00h |
| busy | output | 1 | High while an internal job runs |

## Verification
The assertions assume the following about the inputs:
- Control and address inputs change only between clock edges.
- Every strobe pulse is at least one clock long.
- A read cycle and a write cycle never overlap, since a read requires the write strobe to be high.

The stimulus meets these assumptions. All inputs change on the falling clock edge. Each write or read pulse is held for whole cycles and is followed by at least one idle cycle. Data is held until the last low cycle of the strobe, except in the one test that moves the address and data inside a pulse to exercise the capture points.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_UNL1, S_UNL2, S_PROG, S_ERA3, S_ERA4, S_ERA5
  } seq_st_t;

  typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_SECT, OP_BANK} op_t;

  localparam logic [7:0] D_KEY_A  = 8'hAA;
  localparam logic [7:0] D_KEY_B  = 8'h55;
  localparam logic [7:0] D_PROG   = 8'hA0;
  localparam logic [7:0] D_ERASE  = 8'h80;
  localparam logic [7:0] D_SECTOR = 8'h30;
  localparam logic [7:0] D_WHOLE  = 8'h10;
  localparam logic [15:0] A_KEY_X = 16'h5555;
  localparam logic [15:0] A_KEY_Y = 16'h2AAA;
  localparam int SECT_LSB = 12;

  // program can only pull bits low
  function automatic logic [7:0] prog_merge(logic [7:0] old_b, logic [7:0] new_b);
    return old_b & new_b;
  endfunction

  function automatic logic [7:0] status_byte(op_t op, logic tgt7, logic tog);
    return {(op == OP_PROG) ? ~tgt7 : 1'b0, tog, 6'b0};
  endfunction
endpackage

// File: rtl/flash_strobe.sv
module flash_strobe #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              wr_done,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              rd_act,
  output logic              rd_done
);
  logic wr_act, wr_q, rd_q;

  assign wr_act  = !ce_n && !we_n;
  assign rd_act  = !ce_n && !oe_n && we_n;
  assign wr_done = wr_q && !wr_act;
  assign rd_done = rd_q && !rd_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
      if (wr_act && !wr_q) wr_addr <= addr;  // later strobe falls
      if (wr_act)          wr_data <= wdata; // last value before first rise
    end
  end

  assert_addr_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_act && wr_q) |=> $stable(wr_addr));
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_done,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  output logic              launch,
  output op_t               op
);
  localparam logic [ADDR_W-1:0] AX = ADDR_W'(A_KEY_X);
  localparam logic [ADDR_W-1:0] AY = ADDR_W'(A_KEY_Y);

  seq_st_t st, nxt;

  function automatic logic hit(logic [ADDR_W-1:0] a, logic [7:0] d,
                               logic [ADDR_W-1:0] ea, logic [7:0] ed);
    return (a == ea) && (d == ed);
  endfunction

  always_comb begin
    nxt    = st;
    launch = 1'b0;
    op     = OP_NONE;
    if (wr_done) begin
      nxt = S_IDLE;
      if (!busy) begin
        unique case (st)
          S_IDLE: if (hit(wr_addr, wr_data, AX, D_KEY_A)) nxt = S_UNL1;
          S_UNL1: if (hit(wr_addr, wr_data, AY, D_KEY_B)) nxt = S_UNL2;
          S_UNL2: begin
            if (hit(wr_addr, wr_data, AX, D_PROG))       nxt = S_PROG;
            else if (hit(wr_addr, wr_data, AX, D_ERASE)) nxt = S_ERA3;
          end
          S_PROG: begin launch = 1'b1; op = OP_PROG; end
          S_ERA3: if (hit(wr_addr, wr_data, AX, D_KEY_A)) nxt = S_ERA4;
          S_ERA4: if (hit(wr_addr, wr_data, AY, D_KEY_B)) nxt = S_ERA5;
          S_ERA5: begin
            if (wr_data == D_SECTOR) begin
              launch = 1'b1; op = OP_SECT;
            end else if (hit(wr_addr, wr_data, AX, D_WHOLE)) begin
              launch = 1'b1; op = OP_BANK;
            end
          end
          default: nxt = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= nxt;
  end

  assert_launch_from_tail_R9: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> (st == S_PROG || st == S_ERA5));
endmodule

// File: rtl/flash_core.sv
module flash_core
  import flash_cmd_pkg::*;
#(
  parameter int SECT_KEEP = 2,
  parameter int OFFS_KEEP = 4,
  parameter int PROG_CYC  = 20,
  parameter int SERA_CYC  = 40,
  parameter int BERA_CYC  = 60
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           launch,
  input  op_t                            op,
  input  logic [SECT_KEEP+OFFS_KEEP-1:0] op_idx,
  input  logic [7:0]                     op_data,
  input  logic                           rd_act,
  input  logic                           rd_done,
  input  logic [SECT_KEEP+OFFS_KEEP-1:0] rd_idx,
  output logic                           busy,
  output logic [7:0]                     rdata
);
  localparam int IDX_W = SECT_KEEP + OFFS_KEEP;
  localparam int DEPTH = 1 << IDX_W;
  localparam int MAXL  = (PROG_CYC > SERA_CYC) ?
                         ((PROG_CYC > BERA_CYC) ? PROG_CYC : BERA_CYC) :
                         ((SERA_CYC > BERA_CYC) ? SERA_CYC : BERA_CYC);
  localparam int CNT_W = $clog2(MAXL + 1);

  logic [7:0]       mem [DEPTH];
  op_t              cur;
  logic [IDX_W-1:0] t_idx;
  logic [7:0]       t_data;
  logic [CNT_W-1:0] cnt;
  logic             tog;

  function automatic logic [CNT_W-1:0] job_len(op_t k);
    case (k)
      OP_SECT: return CNT_W'(SERA_CYC - 1);
      OP_BANK: return CNT_W'(BERA_CYC - 1);
      default: return CNT_W'(PROG_CYC - 1);
    endcase
  endfunction

  function automatic logic same_sector(int i, logic [IDX_W-1:0] t);
    logic [IDX_W-1:0] iv;
    iv = IDX_W'(i);
    return iv[IDX_W-1:OFFS_KEEP] == t[IDX_W-1:OFFS_KEEP];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      cur    <= OP_NONE;
      t_idx  <= '0;
      t_data <= '0;
      tog    <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (launch && !busy) begin
      busy   <= 1'b1;
      cnt    <= job_len(op);
      cur    <= op;
      t_idx  <= op_idx;
      t_data <= op_data;
      tog    <= 1'b0;
    end else if (busy) begin
      if (rd_done) tog <= ~tog;
      if (cnt != 0) cnt <= cnt - 1'b1;
      else begin
        busy <= 1'b0;
        case (cur)
          OP_PROG: mem[t_idx] <= prog_merge(mem[t_idx], t_data);
          OP_SECT: for (int i = 0; i < DEPTH; i++)
                     if (same_sector(i, t_idx)) mem[i] <= 8'hFF;
          OP_BANK: for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    if (!rd_act)   rdata = 8'h00;
    else if (busy) rdata = status_byte(cur, t_data[7], tog);
    else           rdata = mem[rd_idx];
  end

  assert_no_launch_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !launch);
  assert_status_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && busy) |-> (rdata[5:0] == 6'd0));
  assert_toggle_flip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_done) |=> (tog != $past(tog)));
  assert_busy_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(cnt) == '0));
endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int SECT_KEEP = 2,
  parameter int OFFS_KEEP = 4,
  parameter int PROG_CYC  = 20,
  parameter int SERA_CYC  = 40,
  parameter int BERA_CYC  = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              busy
);
  localparam int IDX_W = SECT_KEEP + OFFS_KEEP;

  logic              wr_done, rd_act, rd_done, launch;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;
  op_t               op;
  logic [IDX_W-1:0]  op_idx, rd_idx;

  function automatic logic [IDX_W-1:0] to_idx(logic [ADDR_W-1:0] a);
    return {a[SECT_LSB +: SECT_KEEP], a[OFFS_KEEP-1:0]};
  endfunction

  assign op_idx = to_idx(wr_addr);
  assign rd_idx = to_idx(addr);

  flash_strobe #(.ADDR_W(ADDR_W)) u_strobe (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .wr_done(wr_done), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_act(rd_act), .rd_done(rd_done)
  );

  flash_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_done(wr_done), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .launch(launch), .op(op)
  );

  flash_core #(
    .SECT_KEEP(SECT_KEEP), .OFFS_KEEP(OFFS_KEEP),
    .PROG_CYC(PROG_CYC), .SERA_CYC(SERA_CYC), .BERA_CYC(BERA_CYC)
  ) u_core (
    .clk(clk), .rst_n(rst_n), .launch(launch), .op(op), .op_idx(op_idx),
    .op_data(wr_data), .rd_act(rd_act), .rd_done(rd_done), .rd_idx(rd_idx),
    .busy(busy), .rdata(rdata)
  );
endmodule

// File: tb/nor_cmd_decoder_tb.sv
`timescale 1ns/1ps
module nor_cmd_decoder_tb;
  localparam int PROG_CYC = 20;
  localparam int SERA_CYC = 40;
  localparam int BERA_CYC = 60;

  logic        clk = 1'b0, rst_n = 1'b0, ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [17:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        busy;

  int n_run = 0, n_fail = 0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb[$];
  event  smp;

  always #4 clk = ~clk;

  nor_cmd_decoder #(.PROG_CYC(PROG_CYC), .SERA_CYC(SERA_CYC), .BERA_CYC(BERA_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy)
  );

  // monitor: pops expected read results
  always begin
    item_t it;
    @(smp);
    n_run++;
    if (sb.size() == 0) begin
      n_fail++;
      $display("FAIL %s: read with empty scoreboard", "scoreboard");
    end else begin
      it = sb.pop_front();
      if (rdata !== it.exp) begin
        n_fail++;
        $display("FAIL %s: rdata actual %02h expected %02h", it.tag, rdata, it.exp);
      end
    end
  end

  task automatic chk(int act, int exp, string tag);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [17:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic rd(logic [17:0] a, logic [7:0] exp, string tag);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    #1;
    sb.push_back('{exp, tag});
    -> smp;
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic prog(logic [17:0] a, logic [7:0] d);
    wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, 8'hA0); wr(a, d);
  endtask

  task automatic erase_pre();
    wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, 8'h80);
    wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55);
  endtask

  task automatic measure(int len, string tag);
    int n = 0;
    @(negedge clk);
    while (busy) begin n++; @(negedge clk); end
    chk(n, len, tag);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  initial begin
    #(50000 * 8);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk(busy, 0, "R1 busy after reset");
    chk(rdata, 0, "R1 idle rdata");
    rd(18'h00003, 8'hFF, "R1 erased byte");
    rd(18'h0300F, 8'hFF, "R1 erased byte high");

    // R2 / R5 program and job length
    prog(18'h00003, 8'h3C);
    measure(PROG_CYC, "R5 program busy length");
    rd(18'h00003, 8'h3C, "R2 programmed byte");

    // R3 AND merge
    prog(18'h00003, 8'h0F);
    wait_idle();
    rd(18'h00003, 8'h0C, "R3 bits only cleared");

    // R4 capture points: address at start, data at last low cycle
    wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, 8'hA0);
    @(negedge clk); addr = 18'h00007; wdata = 8'h5A; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); addr = 18'h00008; wdata = 8'hA5;
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
    wait_idle();
    rd(18'h00007, 8'hA5, "R4 early address late data");
    rd(18'h00008, 8'hFF, "R4 late address unused");

    // R10 program status
    prog(18'h01003, 8'h00);
    rd(18'h01003, 8'h80, "R10 program status first");
    rd(18'h01003, 8'hC0, "R10 program status toggled");
    wait_idle();
    rd(18'h01003, 8'h00, "R2 second program");

    // R8 commands during a job are discarded
    prog(18'h02003, 8'h00);
    prog(18'h02005, 8'h00);
    wait_idle();
    rd(18'h02005, 8'hFF, "R8 command while busy ignored");
    rd(18'h02003, 8'h00, "R8 running job completes");
    wr(18'h02005, 8'h00);
    @(negedge clk);
    chk(busy, 0, "R8 no leftover sequence state");
    rd(18'h02005, 8'hFF, "R8 no leftover sequence state data");

    // R9 mismatched steps
    wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h11); wr(18'h05555, 8'hA0); wr(18'h00003, 8'h00);
    @(negedge clk);
    chk(busy, 0, "R9 bad unlock no job");
    rd(18'h00003, 8'h0C, "R9 bad unlock array intact");
    erase_pre(); wr(18'h00000, 8'h10);
    @(negedge clk);
    chk(busy, 0, "R9 bank erase wrong address");
    rd(18'h02003, 8'h00, "R9 bank erase wrong address data");

    // R6 / R11 sector erase
    erase_pre(); wr(18'h01000, 8'h30);
    measure(SERA_CYC, "R11 sector erase length");
    rd(18'h01003, 8'hFF, "R6 target sector erased");
    rd(18'h02003, 8'h00, "R6 other sector kept");
    rd(18'h00003, 8'h0C, "R6 sector zero kept");

    // R10 erase status
    erase_pre(); wr(18'h03000, 8'h30);
    rd(18'h03000, 8'h00, "R10 erase status first");
    rd(18'h03000, 8'h40, "R10 erase status toggled");
    wait_idle();

    // R7 / R11 bank erase
    erase_pre(); wr(18'h05555, 8'h10);
    measure(BERA_CYC, "R11 bank erase length");
    rd(18'h02003, 8'hFF, "R7 bank erased a");
    rd(18'h00003, 8'hFF, "R7 bank erased b");
    rd(18'h00007, 8'hFF, "R7 bank erased c");

    repeat (3) @(negedge clk);
    chk(sb.size(), 0, "scoreboard drained");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule